// File: doc/BRIEF.md
# Floppy Drive Control and Status Port

This block is a one-byte I/O port placed next to a floppy disk controller. A write to the port splits the data byte into the drive-facing control lines: a two-bit drive number, a drive-size select, a combined head-load/motor line, a density select and an auto-wait enable. A read captures a status byte built from the controller's data-request (DRQ) and interrupt-request (INTRQ) lines.

The head/motor line is released automatically. While it is active, each pulse on the periodic tick input advances a timeout counter. When the counter reaches its limit, the line drops. Every write clears the counter, so software keeps the motor running by rewriting the port. The disk controller itself lies outside this block.

Top module: `fdc_ctrl_port`

## Requirements
- R1: After reset, every control output and the captured status byte `rdData` read zero.
- R2: A write loads `wrData[1:0]` into `driveSel`, which selects drive 0 to 3, visible the cycle after the write.
- R3: A write loads `wrData[4]` into `miniDrive`. The value 1 selects a 5.25-inch drive and 0 selects an 8-inch drive.
- R4: A write loads `wrData[3]` into `doubleDens` and `wrData[7]` into `autoWait`. Bits 5 and 6 of the write data have no effect on any output.
- R5: A write loads `wrData[2]` into `headSel`. Any write also clears the timeout counter, so a rewrite with bit 2 set restarts the full timeout.
- R6: A cycle with `rdEn` high captures 0xFF into `rdData` when `fdcDrq` is high and 0x00 when it is low. Bit 7 is then forced to 0 when `fdcIntrq` is high. `rdData` holds its value in cycles without `rdEn`.
- R7: While `headSel` is high and no write occurs, `headSel` stays high through 127 ticks and drops in the cycle after the 128th tick (TIMEOUT_TICKS = 128).
- R8: Ticks that arrive while `headSel` is low are not counted and change no output. `headSel` rises only through a write.
- R9: When a write and a tick fall in the same cycle, the write wins. The outputs follow the write data and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control byte |
| wrData | input | 8 | Control byte written by the host |
| rdEn | input | 1 | Read strobe; captures the status byte |
| tick | input | 1 | Periodic one-cycle timeout pulse |
| fdcDrq | input | 1 | Data request from the disk controller |
| fdcIntrq | input | 1 | Interrupt request from the disk controller |
| rdData | output | 8 | Status byte captured by the last read |
| driveSel | output | 2 | Selected drive number |
| miniDrive | output | 1 | 1 = 5.25-inch drive, 0 = 8-inch drive |
| headSel | output | 1 | Head load / motor on |
| doubleDens | output | 1 | Double-density enable |
| autoWait | output | 1 | Auto-wait enable |

## Verification
The bench builds the block with its default parameters: four drives and a timeout of 128 ticks. At that limit, the exact expiry edge (127 ticks still on, 128 off) fits in a few hundred cycles. The bench walks that edge three times: from a fresh write, after a mid-count rewrite, and with a write landing on the tick that would otherwise have expired the line. The full DRQ/INTRQ truth table is exercised, together with the hold of the captured byte while those lines move between reads.

// File: rtl/fdc_ctrl_pkg.sv
package fdc_ctrl_pkg;

  // Write-byte field positions, fixed by the host software interface
  localparam int BYTE_W    = 8;
  localparam int DRV_LSB   = 0;
  localparam int HEAD_BIT  = 2;
  localparam int DENS_BIT  = 3;
  localparam int MINI_BIT  = 4;
  localparam int AWAIT_BIT = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCtrl;   // latch control fields from the write byte
    logic capStatus;  // capture status byte
    logic expire;     // timeout reached: release head select
  } ctlStrobes_t;

endpackage

// File: rtl/fdc_ctrl_seq.sv
module fdc_ctrl_seq
  import fdc_ctrl_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        tick,
  input  logic        headSel,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             countTick;
  logic             atLimit;

  // A write in the same cycle takes priority over the tick
  assign countTick = tick && headSel && !wrEn;
  assign atLimit   = (tickCnt == LAST_CNT);

  assign strobes.loadCtrl  = wrEn;
  assign strobes.capStatus = rdEn;
  assign strobes.expire    = countTick && atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (wrEn) begin
      tickCnt <= '0;
    end else if (countTick) begin
      if (atLimit) tickCnt <= '0;
      else         tickCnt <= tickCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/fdc_ctrl_dp.sv
module fdc_ctrl_dp
  import fdc_ctrl_pkg::*;
#(
  parameter int DRIVES = 4,
  localparam int DRV_W = (DRIVES < 2) ? 1 : $clog2(DRIVES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              fdcDrq,
  input  logic              fdcIntrq,
  output logic [BYTE_W-1:0] rdData,
  output logic [DRV_W-1:0]  driveSel,
  output logic              miniDrive,
  output logic              headSel,
  output logic              doubleDens,
  output logic              autoWait
);
  logic [BYTE_W-1:0] statusByte;

  // All bits follow DRQ, then the top bit is knocked out by INTRQ
  always_comb begin
    statusByte = {BYTE_W{fdcDrq}};
    if (fdcIntrq) statusByte[BYTE_W-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveSel   <= '0;
      miniDrive  <= 1'b0;
      headSel    <= 1'b0;
      doubleDens <= 1'b0;
      autoWait   <= 1'b0;
    end else if (strobes.loadCtrl) begin
      driveSel   <= wrData[DRV_LSB +: DRV_W];
      miniDrive  <= wrData[MINI_BIT];
      headSel    <= wrData[HEAD_BIT];
      doubleDens <= wrData[DENS_BIT];
      autoWait   <= wrData[AWAIT_BIT];
    end else if (strobes.expire) begin
      headSel    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rdData <= '0;
    else if (strobes.capStatus) rdData <= statusByte;
  end

endmodule

// File: rtl/fdc_ctrl_port.sv
module fdc_ctrl_port
  import fdc_ctrl_pkg::*;
#(
  parameter int DRIVES        = 4,
  parameter int TIMEOUT_TICKS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  input  logic       tick,
  input  logic       fdcDrq,
  input  logic       fdcIntrq,
  output logic [7:0] rdData,
  output logic [1:0] driveSel,
  output logic       miniDrive,
  output logic       headSel,
  output logic       doubleDens,
  output logic       autoWait
);
  ctlStrobes_t strobes;

  fdc_ctrl_seq #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) seq_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .tick    (tick),
    .headSel (headSel),
    .strobes (strobes)
  );

  fdc_ctrl_dp #(
    .DRIVES(DRIVES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .fdcDrq     (fdcDrq),
    .fdcIntrq   (fdcIntrq),
    .rdData     (rdData),
    .driveSel   (driveSel),
    .miniDrive  (miniDrive),
    .headSel    (headSel),
    .doubleDens (doubleDens),
    .autoWait   (autoWait)
  );

endmodule

// File: rtl/fdc_ctrl_port_chk.sv
module fdc_ctrl_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       rdEn,
  input logic       tick,
  input logic       fdcDrq,
  input logic       fdcIntrq,
  input logic [7:0] rdData,
  input logic [1:0] driveSel,
  input logic       miniDrive,
  input logic       headSel,
  input logic       doubleDens,
  input logic       autoWait
);
  a_r2_drive_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> driveSel == $past(wrData[1:0]));

  a_r3_size_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> miniDrive == $past(wrData[4]));

  a_r4_dens_wait_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (doubleDens == $past(wrData[3])) && (autoWait == $past(wrData[7])));

  a_r5_head_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> headSel == $past(wrData[2]));

  a_r6_read_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !fdcDrq) |=> rdData == 8'h00);

  a_r6_read_full: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fdcDrq && !fdcIntrq) |=> rdData == 8'hFF);

  a_r6_read_intrq: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fdcIntrq) |=> !rdData[7]);

  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  a_r7_no_drop_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (headSel && !wrEn && !tick) |=> headSel);

  a_r8_no_self_raise: assert property (@(posedge clk) disable iff (!rstN)
    (!headSel && !wrEn) |=> !headSel);

  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(driveSel) && $stable(miniDrive) && $stable(doubleDens) && $stable(autoWait));

endmodule

bind fdc_ctrl_port fdc_ctrl_port_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdEn       (rdEn),
  .tick       (tick),
  .fdcDrq     (fdcDrq),
  .fdcIntrq   (fdcIntrq),
  .rdData     (rdData),
  .driveSel   (driveSel),
  .miniDrive  (miniDrive),
  .headSel    (headSel),
  .doubleDens (doubleDens),
  .autoWait   (autoWait)
);

// File: tb/fdc_ctrl_port_tb_top.sv
`timescale 1ns/1ps
module fdc_ctrl_port_tb_top;

  localparam int LIMIT = 128;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic       tick = 1'b0;
  logic       fdcDrq = 1'b0;
  logic       fdcIntrq = 1'b0;
  logic [7:0] rdData;
  logic [1:0] driveSel;
  logic       miniDrive, headSel, doubleDens, autoWait;

  always #2.5 clk = ~clk;

  fdc_ctrl_port #(.DRIVES(4), .TIMEOUT_TICKS(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .tick(tick), .fdcDrq(fdcDrq), .fdcIntrq(fdcIntrq), .rdData(rdData),
    .driveSel(driveSel), .miniDrive(miniDrive), .headSel(headSel),
    .doubleDens(doubleDens), .autoWait(autoWait)
  );

  typedef struct {
    string       tag;
    logic [13:0] exp;
  } sbItem_t;

  sbItem_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Requirement model
  logic [1:0] mDrive = 0;
  logic       mMini = 0, mHead = 0, mDens = 0, mAw = 0;
  logic [7:0] mRd = 0;
  int         mCnt = 0;

  function automatic logic [13:0] expVec();
    return {mDrive, mMini, mHead, mDens, mAw, mRd};
  endfunction

  // Monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        sbItem_t it;
        logic [13:0] obs;
        it  = sbq.pop_front();
        obs = {driveSel, miniDrive, headSel, doubleDens, autoWait, rdData};
        checks++;
        if (obs !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, obs, it.exp);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, model update, expected push
  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic t, input logic q, input logic i, input string tag);
    @(negedge clk);
    wrEn = w; wrData = d; rdEn = r; tick = t; fdcDrq = q; fdcIntrq = i;
    @(posedge clk);
    if (w) begin
      mDrive = d[1:0]; mHead = d[2]; mDens = d[3]; mMini = d[4]; mAw = d[7];
      mCnt = 0;
    end else if (t && mHead) begin
      if (mCnt == LIMIT - 1) begin mHead = 0; mCnt = 0; end
      else mCnt++;
    end
    if (r) begin
      mRd = q ? 8'hFF : 8'h00;
      if (i) mRd[7] = 1'b0;
    end
    #1;
    sbq.push_back('{tag, expVec()});
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 8'h00, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    sbq.push_back('{"R1 reset", 14'h0});
    @(negedge clk);
    rstN = 1'b1;

    // R2 drive select
    step(1, 8'h03, 0, 0, 0, 0, "R2 drive3");
    step(1, 8'h01, 0, 0, 0, 0, "R2 drive1");
    step(1, 8'h02, 0, 0, 0, 0, "R2 drive2");
    step(1, 8'h00, 0, 0, 0, 0, "R2 drive0");
    // R3 drive size
    step(1, 8'h10, 0, 0, 0, 0, "R3 mini");
    step(1, 8'h00, 0, 0, 0, 0, "R3 eight-inch");
    // R4 density, auto-wait, ignored bits
    step(1, 8'h88, 0, 0, 0, 0, "R4 dens+wait");
    step(1, 8'h60, 0, 0, 0, 0, "R4 bits 5,6 ignored");
    step(0, 8'hFF, 0, 0, 0, 0, "R4 no write");
    // R6 status reads
    step(0, 8'h00, 1, 0, 1, 0, "R6 drq");
    step(0, 8'h00, 1, 0, 0, 0, "R6 idle");
    step(0, 8'h00, 1, 0, 1, 1, "R6 drq+intrq");
    step(0, 8'h00, 0, 0, 0, 0, "R6 hold");
    step(0, 8'h00, 0, 0, 1, 0, "R6 hold drq moves");
    step(0, 8'h00, 1, 0, 0, 1, "R6 intrq only");
    // R7 timeout edge
    step(1, 8'h04, 0, 0, 0, 0, "R5 head on");
    ticks(LIMIT, "R7 timeout");
    // R8 ticks while inactive
    ticks(20, "R8 idle ticks");
    // R5 rewrite restarts count
    step(1, 8'h04, 0, 0, 0, 0, "R5 head on again");
    ticks(100, "R5 partial");
    step(1, 8'h04, 0, 0, 0, 0, "R5 rewrite");
    ticks(LIMIT, "R5 full restart");
    // R9 write collides with expiring tick
    step(1, 8'h04, 0, 0, 0, 0, "R9 head on");
    ticks(LIMIT - 1, "R9 pre");
    step(1, 8'h04, 0, 1, 0, 0, "R9 write wins");
    ticks(LIMIT, "R9 post");
    // Write clearing head, plus combined write/read
    step(1, 8'h97, 1, 1, 1, 0, "R2 combined");
    step(1, 8'h00, 0, 1, 0, 0, "R5 head off by write");
    ticks(4, "R8 off ticks");
    step(0, 8'h00, 0, 0, 0, 0, "R1 idle");

    @(posedge clk); #3;
    while (sbq.size() > 0) begin @(posedge clk); #3; end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule